// File: doc/BRIEF.md
# Target Latency Rule Monitor

This block watches each bus transaction in which the device is the target. It times every data phase against the bus latency rule. The first beat of a transaction has a long deadline. Each later beat has a shorter deadline, counted from the beat before it. If a deadline passes with no beat and no internal data ready, the block asks the bus interface to end the transaction. It asks for a retry when no data has moved yet, and for a disconnect when at least one beat has completed.

The owning interface drives five inputs: a start strobe in the address-phase cycle, an end strobe when the transaction closes, a strobe for each completed data beat, a flag that says internal data is ready, and a control bit that waives the rule. The waiver only counts if the block sees it early enough in the current phase. The outputs are two one-cycle request pulses. At most one request is issued per transaction. The deadlines, waiver windows and output timing are parameters. The defaults are 16 and 8 clocks for the deadlines, 15 and 7 for the waiver windows, and registered outputs.

Top module: `tlat_monitor`

## Requirements
- R1: While reset is held and after it is released with no traffic, `retry_req` and `disc_req` are both 0, and the waiver bit is taken as clear.
- R2: If a transaction starts at clock edge S and no beat completes, `data_ready` stays 0 and no waiver applies, `retry_req` is 1 for exactly the one cycle following edge S+16.
- R3: Each completed beat at edge B restarts an 8-clock window. If no further beat arrives, `disc_req` is 1 for exactly the one cycle following edge B+8.
- R4: A beat sampled at the deadline edge itself (S+16 for the first beat, B+8 for later beats) counts as being in time, so no request follows.
- R5: In the first phase, the waiver bit is honoured if it is sampled high at the start edge or at any edge S+1 to S+14. If it first rises at edge S+15 or later, the retry still occurs.
- R6: In a later phase, the waiver bit is honoured if it is sampled high at the beat edge or at any edge B+1 to B+6. If it first rises at edge B+7 or later, the disconnect still occurs. A waiver from one phase does not carry into the next phase.
- R7: While `data_ready` is 1 at and after the deadline, the request is held off. It is issued in the cycle after the first edge at which `data_ready` is 0 and no beat is sampled.
- R8: Requests are single-cycle pulses. `retry_req` and `disc_req` are never 1 together. At most one request is issued between a start and the next start or end.
- R9: An end strobe returns the block to idle, and no request follows it. A new start restarts timing from the first phase. If start and end are sampled at the same edge, the end takes priority.
- R10: A retry is issued only when no beat has completed since the start. A disconnect is issued only after at least one beat has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Address-phase strobe of a transaction targeting this device |
| txn_end | input | 1 | Transaction-closed strobe |
| beat_done | input | 1 | A data beat completed in this cycle |
| data_ready | input | 1 | Internal data is available for the pending beat |
| lat_rule_off | input | 1 | Waiver control bit for the latency rule |
| retry_req | output | 1 | One-cycle request to retry (no data moved yet) |
| disc_req | output | 1 | One-cycle request to disconnect (data already moved) |

## Verification
A phase age counter that is off by one moves a request pulse by exactly one cycle. The bench catches this because it checks every pulse against the exact cycle predicted from the strobe edges. A waiver flag that is latched in the wrong window, or not cleared at a beat, shows up within one phase: a pulse appears or goes missing 8 or 16 clocks after the phase began. A stale one-shot flag or phase state shows up at the next transaction's deadline, as a missing pulse or a pulse of the wrong kind.

// File: rtl/tlm_pkg.sv
package tlm_pkg;

   // Which deadline the current data phase is timed against
   typedef enum logic {
      PH_FIRST = 1'b0,
      PH_LATER = 1'b1
   } phase_e;

endpackage

// File: rtl/tlm_phase_timer.sv
// Tracks whether a transaction is open, which phase it is in and how many
// clocks have passed in that phase. The age saturates at the phase deadline.
module tlm_phase_timer
   import tlm_pkg::*;
#(
   parameter int FIRST_LIMIT = 16,
   parameter int LATER_LIMIT = 8,
   parameter int AW          = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          end_i,
   input  logic          beat_i,
   output logic          active_o,
   output phase_e        phase_o,
   output logic [AW-1:0] age_o,
   output logic          at_limit_o
);

   localparam logic [AW-1:0] FIRST_LIM_V = AW'(FIRST_LIMIT);
   localparam logic [AW-1:0] LATER_LIM_V = AW'(LATER_LIMIT);
   localparam logic [AW-1:0] AGE_ONE     = AW'(1);

   logic          active_q;
   phase_e        phase_q;
   logic [AW-1:0] age_q;
   logic [AW-1:0] limit_w;
   logic          reached_w;

   always_comb begin
      limit_w   = (phase_q == PH_FIRST) ? FIRST_LIM_V : LATER_LIM_V;
      reached_w = (age_q >= limit_w);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         phase_q  <= PH_FIRST;
         age_q    <= '0;
      end else if (end_i) begin
         active_q <= 1'b0;
         phase_q  <= PH_FIRST;
         age_q    <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         phase_q  <= PH_FIRST;
         age_q    <= AGE_ONE;
      end else if (active_q && beat_i) begin
         phase_q  <= PH_LATER;
         age_q    <= AGE_ONE;
      end else if (active_q && !reached_w) begin
         age_q    <= age_q + AGE_ONE;
      end
   end

   assign active_o   = active_q;
   assign phase_o    = phase_q;
   assign age_o      = age_q;
   assign at_limit_o = active_q && reached_w;

endmodule

// File: rtl/tlm_waiver.sv
// Captures the waiver bit for the current phase. It is honoured only if seen
// at the phase restart edge or while the phase age is below its grace window.
module tlm_waiver
   import tlm_pkg::*;
#(
   parameter int FIRST_GRACE = 15,
   parameter int LATER_GRACE = 7,
   parameter int AW          = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          restart_i,
   input  logic          active_i,
   input  phase_e        phase_i,
   input  logic [AW-1:0] age_i,
   input  logic          dis_i,
   output logic          waived_o
);

   localparam logic [AW-1:0] FIRST_GRACE_V = AW'(FIRST_GRACE);
   localparam logic [AW-1:0] LATER_GRACE_V = AW'(LATER_GRACE);

   logic [AW-1:0] grace_w;
   logic          in_window_w;
   logic          waived_q;

   always_comb begin
      grace_w     = (phase_i == PH_FIRST) ? FIRST_GRACE_V : LATER_GRACE_V;
      in_window_w = active_i && (age_i < grace_w);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         waived_q <= 1'b0;
      end else if (clear_i) begin
         waived_q <= 1'b0;
      end else if (restart_i) begin
         waived_q <= dis_i;
      end else if (dis_i && in_window_w) begin
         waived_q <= 1'b1;
      end
   end

   assign waived_o = waived_q;

endmodule

// File: rtl/tlm_expiry.sv
// Decides when a deadline has expired. It raises at most one request per
// transaction, and the output stage is registered or combinational.
module tlm_expiry
   import tlm_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start_i,
   input  logic   end_i,
   input  logic   active_i,
   input  logic   at_limit_i,
   input  logic   waived_i,
   input  logic   beat_i,
   input  logic   ready_i,
   input  phase_e phase_i,
   output logic   retry_o,
   output logic   disc_o
);

   logic fired_q;
   logic fire_w;
   logic retry_w;
   logic disc_w;

   always_comb begin
      fire_w  = active_i && at_limit_i && !beat_i && !ready_i && !waived_i
                && !fired_q && !start_i && !end_i;
      retry_w = fire_w && (phase_i == PH_FIRST);
      disc_w  = fire_w && (phase_i == PH_LATER);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fired_q <= 1'b0;
      end else if (start_i || end_i) begin
         fired_q <= 1'b0;
      end else if (fire_w) begin
         fired_q <= 1'b1;
      end
   end

   generate
      if (OUT_REG) begin : g_out_reg
         logic retry_q;
         logic disc_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               retry_q <= 1'b0;
               disc_q  <= 1'b0;
            end else begin
               retry_q <= retry_w;
               disc_q  <= disc_w;
            end
         end
         assign retry_o = retry_q;
         assign disc_o  = disc_q;
      end else begin : g_out_comb
         assign retry_o = retry_w;
         assign disc_o  = disc_w;
      end
   endgenerate

endmodule

// File: rtl/tlat_monitor.sv
module tlat_monitor
   import tlm_pkg::*;
#(
   parameter int FIRST_LIMIT = 16,
   parameter int LATER_LIMIT = 8,
   parameter int FIRST_GRACE = 15,
   parameter int LATER_GRACE = 7,
   parameter bit OUT_REG     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic txn_start,
   input  logic txn_end,
   input  logic beat_done,
   input  logic data_ready,
   input  logic lat_rule_off,
   output logic retry_req,
   output logic disc_req
);

   localparam int AW = $clog2(FIRST_LIMIT + 1);

   generate
      if (FIRST_LIMIT < 2 || LATER_LIMIT < 2) begin : g_bad_limit
         $error("tlat_monitor: deadlines must be at least 2 clocks");
      end
      if (LATER_LIMIT > FIRST_LIMIT) begin : g_bad_order
         $error("tlat_monitor: later deadline exceeds first deadline");
      end
      if (FIRST_GRACE < 1 || FIRST_GRACE > FIRST_LIMIT) begin : g_bad_fgrace
         $error("tlat_monitor: first grace window out of range");
      end
      if (LATER_GRACE < 1 || LATER_GRACE > LATER_LIMIT) begin : g_bad_lgrace
         $error("tlat_monitor: later grace window out of range");
      end
   endgenerate

   logic          active_w;
   phase_e        phase_w;
   logic [AW-1:0] age_w;
   logic          at_limit_w;
   logic          waived_w;
   logic          restart_w;

   assign restart_w = txn_start || (active_w && beat_done);

   tlm_phase_timer #(
      .FIRST_LIMIT (FIRST_LIMIT),
      .LATER_LIMIT (LATER_LIMIT),
      .AW          (AW)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (txn_start),
      .end_i      (txn_end),
      .beat_i     (beat_done),
      .active_o   (active_w),
      .phase_o    (phase_w),
      .age_o      (age_w),
      .at_limit_o (at_limit_w)
   );

   tlm_waiver #(
      .FIRST_GRACE (FIRST_GRACE),
      .LATER_GRACE (LATER_GRACE),
      .AW          (AW)
   ) u_waiver (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (txn_end),
      .restart_i (restart_w),
      .active_i  (active_w),
      .phase_i   (phase_w),
      .age_i     (age_w),
      .dis_i     (lat_rule_off),
      .waived_o  (waived_w)
   );

   tlm_expiry #(
      .OUT_REG (OUT_REG)
   ) u_expiry (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (txn_start),
      .end_i      (txn_end),
      .active_i   (active_w),
      .at_limit_i (at_limit_w),
      .waived_i   (waived_w),
      .beat_i     (beat_done),
      .ready_i    (data_ready),
      .phase_i    (phase_w),
      .retry_o    (retry_req),
      .disc_o     (disc_req)
   );

endmodule

// File: rtl/tlm_checker.sv
module tlm_checker #(
   parameter int FIRST_LIMIT = 16,
   parameter int LATER_LIMIT = 8
) (
   input logic clk,
   input logic rst_n,
   input logic txn_start,
   input logic txn_end,
   input logic beat_done,
   input logic retry_req,
   input logic disc_req
);

   localparam int CW = $clog2(FIRST_LIMIT + 2) + 1;
   localparam logic [CW-1:0] SAT_V   = CW'(FIRST_LIMIT + 1);
   localparam logic [CW-1:0] FIRST_V = CW'(FIRST_LIMIT);
   localparam logic [CW-1:0] LATER_V = CW'(LATER_LIMIT);

   logic          chk_active;
   logic          chk_seen;
   logic [CW-1:0] chk_age;
   logic [1:0]    chk_reqs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_active <= 1'b0;
         chk_seen   <= 1'b0;
         chk_age    <= '0;
         chk_reqs   <= '0;
      end else if (txn_end) begin
         chk_active <= 1'b0;
         chk_seen   <= 1'b0;
         chk_age    <= '0;
         chk_reqs   <= '0;
      end else if (txn_start) begin
         chk_active <= 1'b1;
         chk_seen   <= 1'b0;
         chk_age    <= CW'(1);
         chk_reqs   <= '0;
      end else begin
         if (chk_active && beat_done) begin
            chk_seen <= 1'b1;
            chk_age  <= CW'(1);
         end else if (chk_active && chk_age < SAT_V) begin
            chk_age  <= chk_age + CW'(1);
         end
         if ((retry_req || disc_req) && chk_reqs != 2'd3) begin
            chk_reqs <= chk_reqs + 2'd1;
         end
      end
   end

   assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(retry_req && disc_req));

   assert_retry_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |=> !retry_req);

   assert_disc_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      disc_req |=> !disc_req);

   assert_one_per_txn_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chk_reqs <= 2'd1);

   assert_retry_no_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |-> !chk_seen);

   assert_disc_after_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
      disc_req |-> chk_seen);

   assert_first_deadline_R2: assert property (@(posedge clk) disable iff (!rst_n)
      retry_req |-> chk_age >= FIRST_V);

   assert_later_deadline_R3: assert property (@(posedge clk) disable iff (!rst_n)
      disc_req |-> chk_age >= LATER_V);

   assert_only_when_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_req || disc_req) |-> ($past(chk_active) && !$past(txn_end)));

endmodule

bind tlat_monitor tlm_checker #(
   .FIRST_LIMIT (FIRST_LIMIT),
   .LATER_LIMIT (LATER_LIMIT)
) u_tlm_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .txn_start (txn_start),
   .txn_end   (txn_end),
   .beat_done (beat_done),
   .retry_req (retry_req),
   .disc_req  (disc_req)
);

// File: tb/tlat_monitor_bench.sv
`timescale 1ns/1ps
module tlat_monitor_bench;

   typedef struct {
      int    cyc;
      bit    disc;
      string tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txn_start = 1'b0;
   logic txn_end = 1'b0;
   logic beat_done = 1'b0;
   logic data_ready = 1'b0;
   logic lat_rule_off = 1'b0;
   logic retry_req;
   logic disc_req;

   int   cyc = 0;
   int   base = 0;
   int   checks = 0;
   int   fails = 0;
   bit   mon_on = 1'b0;
   exp_t exp_q[$];

   always #10 clk = ~clk;   // 50 MHz

   always @(posedge clk) cyc <= cyc + 1;

   tlat_monitor u_tlat_monitor (
      .clk          (clk),
      .rst_n        (rst_n),
      .txn_start    (txn_start),
      .txn_end      (txn_end),
      .beat_done    (beat_done),
      .data_ready   (data_ready),
      .lat_rule_off (lat_rule_off),
      .retry_req    (retry_req),
      .disc_req     (disc_req)
   );

   // Monitor: every observed request is compared against the queue head
   always @(negedge clk) begin
      if (mon_on && (retry_req || disc_req)) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R8 unexpected request at cycle %0d: retry=%0b disc=%0b, expected none",
                     cyc, retry_req, disc_req);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (e.cyc != cyc || e.disc != disc_req || retry_req == disc_req) begin
               fails++;
               $display("FAIL %s request at cycle %0d retry=%0b disc=%0b, expected cycle %0d %s",
                        e.tag, cyc, retry_req, disc_req, e.cyc, e.disc ? "disc" : "retry");
            end
         end
      end
   end

   task automatic expect_req(input int at, input bit disc, input string tag);
      exp_t e;
      e.cyc = at; e.disc = disc; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic expect_done(input string tag);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL %s pending requests never seen: actual %0d outstanding, expected 0",
                  tag, exp_q.size());
         exp_q.delete();
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_txn();
      txn_start = 1'b1;
      @(negedge clk);
      txn_start = 1'b0;
      base = cyc;
   endtask

   task automatic end_txn();
      txn_end = 1'b1;
      @(negedge clk);
      txn_end = 1'b0;
   endtask

   // beat sampled at edge base+k
   task automatic beat_after(input int k);
      repeat (k - 1) @(negedge clk);
      beat_done = 1'b1;
      @(negedge clk);
      beat_done = 1'b0;
      base = cyc;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      // R1: reset state
      idle(4);
      checks++;
      if (retry_req !== 1'b0 || disc_req !== 1'b0) begin
         fails++;
         $display("FAIL R1 outputs in reset: retry=%0b disc=%0b, expected 0 0", retry_req, disc_req);
      end
      rst_n = 1'b1;
      mon_on = 1'b1;
      idle(20);
      expect_done("R1");

      // R2/R10: no beat -> retry after edge S+16
      start_txn();
      expect_req(base + 16, 1'b0, "R2");
      idle(20);
      end_txn();
      idle(2);
      expect_done("R2");

      // R4/R3: beat exactly at deadline edges, then disconnect 8 after last beat
      start_txn();
      beat_after(16);
      beat_after(8);
      expect_req(base + 8, 1'b1, "R3");
      idle(12);
      end_txn();
      idle(2);
      expect_done("R4");

      // R5: waiver seen at edge S+14 is honoured
      start_txn();
      idle(13);
      lat_rule_off = 1'b1;
      idle(20);
      end_txn();
      lat_rule_off = 1'b0;
      idle(2);
      expect_done("R5 waiver at clock 14");

      // R5: waiver first seen at edge S+15 is too late
      start_txn();
      expect_req(base + 16, 1'b0, "R5");
      idle(14);
      lat_rule_off = 1'b1;
      idle(10);
      end_txn();
      lat_rule_off = 1'b0;
      idle(2);
      expect_done("R5 late waiver");

      // R6: waiver at edge B+6 in a later phase is honoured
      start_txn();
      beat_after(3);
      idle(5);
      lat_rule_off = 1'b1;
      idle(14);
      end_txn();
      lat_rule_off = 1'b0;
      idle(2);
      expect_done("R6 waiver at clock 6");

      // R6: waiver first seen at edge B+7 is too late
      start_txn();
      beat_after(2);
      expect_req(base + 8, 1'b1, "R6");
      idle(6);
      lat_rule_off = 1'b1;
      idle(8);
      end_txn();
      lat_rule_off = 1'b0;
      idle(2);
      expect_done("R6 late waiver");

      // R6: first-phase waiver does not carry into the next phase
      start_txn();
      idle(4);
      lat_rule_off = 1'b1;
      idle(1);
      lat_rule_off = 1'b0;
      idle(14);
      beat_after(1);
      expect_req(base + 8, 1'b1, "R6");
      idle(12);
      end_txn();
      idle(2);
      expect_done("R6 waiver per phase");

      // R7: data_ready held over the deadline defers the retry
      start_txn();
      expect_req(base + 21, 1'b0, "R7");
      idle(9);
      data_ready = 1'b1;
      idle(11);
      data_ready = 1'b0;
      idle(6);
      end_txn();
      idle(2);
      expect_done("R7");

      // R9: end before deadline gives no request; new start retimes
      start_txn();
      idle(9);
      end_txn();
      idle(25);
      expect_done("R9 end before deadline");
      start_txn();
      expect_req(base + 16, 1'b0, "R9");
      idle(19);
      end_txn();
      idle(2);
      expect_done("R9 restart");

      // R9: start and end at the same edge -> idle
      txn_start = 1'b1;
      txn_end = 1'b1;
      idle(1);
      txn_start = 1'b0;
      txn_end = 1'b0;
      idle(25);
      expect_done("R9 start with end");

      // R8/R10: after a retry, a later beat and long gap give no disconnect
      start_txn();
      expect_req(base + 16, 1'b0, "R8");
      beat_after(19);
      idle(20);
      end_txn();
      idle(2);
      expect_done("R8 one per transaction");

      // R3: several in-time beats then a timeout
      start_txn();
      beat_after(5);
      beat_after(7);
      beat_after(2);
      expect_req(base + 8, 1'b1, "R3");
      idle(10);
      end_txn();
      idle(2);
      expect_done("R3 multi beat");

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule